// File: doc/BRIEF.md
# Programmable Chip-Select Timing Generator

This block sits on the processor side of a synchronous bus. It turns a single-clock transfer request into a timed access cycle for one external peripheral. A request carries a 32-bit address and a direction bit. The address is checked against a programmable region, given as a base field and a mask field over the upper address bits and gated by an enable bit. A request that hits the region produces an active-low chip select, an active-low output-enable strobe on reads and an active-low write strobe on writes. A bus-drive indication stays high while address, data and attributes must stay on the bus.

Configuration inputs set the timing of each access. One bit adds an address-setup clock before the chip select. A 5-bit wait field lengthens the strobe phase. Two separate bits add one hold clock after the strobes negate, one for writes and one for reads. A done pulse marks the last clock of every access. A request that misses the region completes at once with a no-match flag and drives no strobes. For example, with a 48 MHz bus, setup enabled and 3 wait clocks, the chip select stays low for 5 clocks (about 104 ns).

The controller is a five-state machine. `ST_IDLE` accepts a request. `ST_SETUP` is the optional setup clock. `ST_STROBE` holds chip select and a strobe low. `ST_HOLD` is the optional hold clock. `ST_MISS` is the one-clock completion of a request outside the region. The transitions are:
- idle to setup: hit with setup enabled.
- idle to strobe: hit with setup disabled.
- idle to miss: request outside the region.
- setup to strobe: always, after one clock.
- strobe to hold: wait count exhausted and the hold bit for this direction is set.
- strobe to idle: wait count exhausted and no hold bit applies.
- hold to idle: always, after one clock.
- miss to idle: always, after one clock.

Top module: `cs_timing_gen`

## Requirements
- R1: After reset, chip select, output enable and write strobe are high (inactive), and drive, done, no-match and busy are low.
- R2: A request hits when `cfg_en` is 1 and `addr[31:12]` equals `cfg_base` on every bit where `cfg_mask` is 1. Bits where the mask is 0 are not compared.
- R3: A request that misses spends exactly one clock in the cycle. In the clock after acceptance, done, no-match and busy are high, drive is low and all strobes stay high.
- R4: With `cfg_aset` = 1, the first clock of a hit has drive high and chip select still high. Chip select and the strobe go low in the next clock, and this holds for writes as well.
- R5: Chip select is low for exactly `cfg_ws` + 2 consecutive clocks. On reads (`wr` = 0), output enable is low in those same clocks and the write strobe stays high. On writes (`wr` = 1), the write strobe is low in those clocks and output enable stays high.
- R6: With `cfg_wrah` = 1, a write has one extra final clock with drive high and all strobes high. `cfg_wrah` does not lengthen reads.
- R7: With `cfg_rdah` = 1, a read has one extra final clock with drive high and all strobes high. `cfg_rdah` does not lengthen writes.
- R8: A hit lasts `cfg_aset` + 2 + `cfg_ws` + (applicable hold bit) clocks. Drive and busy are high in every one of them. Done is high only in the last one, and all outputs return to idle values in the next clock.
- R9: `req` is ignored while busy. Holding it high during a cycle leaves that cycle's length and strobes unchanged and starts no second cycle.
- R10: With `cfg_en` = 0, every request is a miss, whatever the address, base and mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Transfer request, sampled only when idle |
| addr | input | 32 | Transfer address |
| wr | input | 1 | Direction: 1 write, 0 read |
| cfg_base | input | 20 | Region base, compared against addr[31:12] |
| cfg_mask | input | 20 | Compare mask, 1 = bit compared |
| cfg_en | input | 1 | Region enable |
| cfg_aset | input | 1 | Address-setup clock enable |
| cfg_ws | input | 5 | Wait clocks added to the strobe phase |
| cfg_wrah | input | 1 | Extra hold clock on writes |
| cfg_rdah | input | 1 | Extra hold clock on reads |
| cs_n | output | 1 | Chip select, active low |
| oe_n | output | 1 | Read output enable, active low |
| we_n | output | 1 | Write strobe, active low |
| bus_drive | output | 1 | Address/data/attributes must be driven |
| done | output | 1 | Last clock of the access |
| nomatch | output | 1 | Access completed without a region hit |
| busy | output | 1 | Access in progress |

## Verification
The assertions assume that `addr`, `wr` and every configuration input stay stable from the accepting clock edge until done. The machine captures the direction and the hold choice at acceptance, but it reads setup and region data from the live inputs. The bench therefore changes configuration and address only between accesses, once the outputs are back at their idle values. During an access it toggles only `req`, which exercises the ignore rule. Randomised accesses mix hits and misses, both directions and every timing option, alongside directed cases for the largest wait count, partial masks and a disabled region.

// File: rtl/cs_timing_pkg.sv
package cs_timing_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETUP  = 3'd1,
        ST_STROBE = 3'd2,
        ST_HOLD   = 3'd3,
        ST_MISS   = 3'd4
    } cs_state_t;

endpackage

// File: rtl/cs_region_match.sv
module cs_region_match #(
    parameter int ADDR_W   = 32,
    parameter int PAGE_LSB = 12,
    localparam int TAG_W   = ADDR_W - PAGE_LSB
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [TAG_W-1:0]  base,
    input  logic [TAG_W-1:0]  mask,
    input  logic              en,
    output logic              hit
);

    logic [TAG_W-1:0] diff;

    // Per-bit compare: a bit mismatches only where the mask selects it.
    genvar g;
    generate
        for (g = 0; g < TAG_W; g++) begin : g_bit
            assign diff[g] = mask[g] & (addr[PAGE_LSB+g] ^ base[g]);
        end
    endgenerate

    assign hit = en & ~(|diff);

endmodule

// File: rtl/cs_wait_counter.sv
module cs_wait_counter #(
    parameter int WS_W    = 5,
    localparam int CNT_W  = WS_W + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [WS_W-1:0] ws,
    input  logic            dec,
    output logic            zero
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= CNT_W'(ws) + CNT_W'(1);
        end else if (dec && cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign zero = (cnt == '0);

    // R5: a freshly loaded count always yields at least two strobe clocks
    assert_load_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !zero);

endmodule

// File: rtl/cs_cycle_fsm.sv
module cs_cycle_fsm
    import cs_timing_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic hit,
    input  logic wr,
    input  logic cfg_aset,
    input  logic cfg_wrah,
    input  logic cfg_rdah,
    input  logic cnt_zero,
    output logic cnt_load,
    output logic cnt_dec,
    output logic cs_n,
    output logic oe_n,
    output logic we_n,
    output logic bus_drive,
    output logic done,
    output logic nomatch,
    output logic busy
);

    cs_state_t state, state_nx;
    logic      wr_q;
    logic      hold_q;
    logic      accept;

    assign accept   = (state == ST_IDLE) && req;
    assign cnt_load = accept && hit;
    assign cnt_dec  = (state == ST_STROBE);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (req) begin
                    if (!hit)          state_nx = ST_MISS;
                    else if (cfg_aset) state_nx = ST_SETUP;
                    else               state_nx = ST_STROBE;
                end
            end
            ST_SETUP:  state_nx = ST_STROBE;
            ST_STROBE: begin
                if (cnt_zero) state_nx = hold_q ? ST_HOLD : ST_IDLE;
            end
            ST_HOLD:   state_nx = ST_IDLE;
            ST_MISS:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            wr_q   <= 1'b0;
            hold_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (accept) begin
                wr_q   <= wr;
                hold_q <= wr ? cfg_wrah : cfg_rdah;
            end
        end
    end

    always_comb begin
        cs_n      = 1'b1;
        oe_n      = 1'b1;
        we_n      = 1'b1;
        bus_drive = 1'b0;
        done      = 1'b0;
        nomatch   = 1'b0;
        busy      = 1'b1;
        unique case (state)
            ST_IDLE:   busy = 1'b0;
            ST_SETUP:  bus_drive = 1'b1;
            ST_STROBE: begin
                bus_drive = 1'b1;
                cs_n      = 1'b0;
                oe_n      = wr_q;
                we_n      = ~wr_q;
                done      = cnt_zero && !hold_q;
            end
            ST_HOLD: begin
                bus_drive = 1'b1;
                done      = 1'b1;
            end
            ST_MISS: begin
                done    = 1'b1;
                nomatch = 1'b1;
            end
            default: busy = 1'b0;
        endcase
    end

    // R4: the setup clock is always followed by the strobe phase
    assert_setup_then_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETUP) |=> (state == ST_STROBE));

    // R8: done never lasts more than one clock
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: the drive window only closes after a done clock
    assert_drive_ends_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_drive) |-> $past(done));

    // R9: a request arriving mid-cycle does not restart the machine
    assert_busy_ignores_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STROBE && !cnt_zero) |=> (state == ST_STROBE));

endmodule

// File: rtl/cs_timing_gen.sv
module cs_timing_gen #(
    parameter int ADDR_W   = 32,
    parameter int PAGE_LSB = 12,
    parameter int WS_W     = 5,
    localparam int TAG_W   = ADDR_W - PAGE_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [TAG_W-1:0]  cfg_base,
    input  logic [TAG_W-1:0]  cfg_mask,
    input  logic              cfg_en,
    input  logic              cfg_aset,
    input  logic [WS_W-1:0]   cfg_ws,
    input  logic              cfg_wrah,
    input  logic              cfg_rdah,
    output logic              cs_n,
    output logic              oe_n,
    output logic              we_n,
    output logic              bus_drive,
    output logic              done,
    output logic              nomatch,
    output logic              busy
);

    logic hit;
    logic cnt_load;
    logic cnt_dec;
    logic cnt_zero;

    cs_region_match #(
        .ADDR_W   (ADDR_W),
        .PAGE_LSB (PAGE_LSB)
    ) u_match (
        .addr (addr),
        .base (cfg_base),
        .mask (cfg_mask),
        .en   (cfg_en),
        .hit  (hit)
    );

    cs_wait_counter #(
        .WS_W (WS_W)
    ) u_wait (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cnt_load),
        .ws    (cfg_ws),
        .dec   (cnt_dec),
        .zero  (cnt_zero)
    );

    cs_cycle_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .hit       (hit),
        .wr        (wr),
        .cfg_aset  (cfg_aset),
        .cfg_wrah  (cfg_wrah),
        .cfg_rdah  (cfg_rdah),
        .cnt_zero  (cnt_zero),
        .cnt_load  (cnt_load),
        .cnt_dec   (cnt_dec),
        .cs_n      (cs_n),
        .oe_n      (oe_n),
        .we_n      (we_n),
        .bus_drive (bus_drive),
        .done      (done),
        .nomatch   (nomatch),
        .busy      (busy)
    );

    // R5: read and write strobes are never active together
    assert_strobe_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!oe_n && !we_n));

    // R3: a no-match completion never comes with chip select
    assert_miss_no_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        nomatch |-> (cs_n && !bus_drive && done));

endmodule

// File: tb/cs_timing_gen_bench.sv
module cs_timing_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [31:0] addr = '0;
    logic        wr = 1'b0;
    logic [19:0] cfg_base = '0;
    logic [19:0] cfg_mask = '0;
    logic        cfg_en = 1'b0;
    logic        cfg_aset = 1'b0;
    logic [4:0]  cfg_ws = '0;
    logic        cfg_wrah = 1'b0;
    logic        cfg_rdah = 1'b0;
    logic        cs_n, oe_n, we_n, bus_drive, done, nomatch, busy;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    cs_timing_gen u_cs_timing_gen (
        .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .wr(wr),
        .cfg_base(cfg_base), .cfg_mask(cfg_mask), .cfg_en(cfg_en),
        .cfg_aset(cfg_aset), .cfg_ws(cfg_ws), .cfg_wrah(cfg_wrah),
        .cfg_rdah(cfg_rdah), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
        .bus_drive(bus_drive), .done(done), .nomatch(nomatch), .busy(busy)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung (actual %0d cycles, expected < 100000)", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic bit exp_hit(input logic [31:0] a);
        return cfg_en && ((((a[31:12] ^ cfg_base) & cfg_mask)) == 20'd0);
    endfunction

    // order: cs_n, oe_n, we_n, bus_drive, done, nomatch, busy
    function automatic logic [6:0] exp_vec(input bit h, input bit w, input int i, input int len);
        bit strobe;
        if (!h) return 7'b1110111;
        strobe = (i > int'(cfg_aset)) && (i <= int'(cfg_aset) + int'(cfg_ws) + 2);
        return {!strobe, !(strobe && !w), !(strobe && w), 1'b1, (i == len), 1'b0, 1'b1};
    endfunction

    task automatic compare(input logic [6:0] expv, input string tag, input int i);
        logic [6:0] act;
        act = {cs_n, oe_n, we_n, bus_drive, done, nomatch, busy};
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s clock %0d: actual %b expected %b", tag, i, act, expv);
        end
    endtask

    task automatic run(input logic [31:0] a, input bit w, input bit noise, input string tag);
        bit h;
        int len;
        h = exp_hit(a);
        len = h ? int'(cfg_aset) + 2 + int'(cfg_ws) + int'(w ? cfg_wrah : cfg_rdah) : 1;
        @(negedge clk);
        addr = a;
        wr   = w;
        req  = 1'b1;
        for (int i = 1; i <= len; i++) begin
            @(negedge clk);
            compare(exp_vec(h, w, i, len), tag, i);
            req = noise;
        end
        @(negedge clk);
        compare(7'b1110000, tag, len + 1);
        req = 1'b0;
    endtask

    task automatic set_cfg(input logic [19:0] b, input logic [19:0] m, input bit en,
                           input bit aset, input logic [4:0] ws, input bit wh, input bit rh);
        cfg_base = b; cfg_mask = m; cfg_en = en;
        cfg_aset = aset; cfg_ws = ws; cfg_wrah = wh; cfg_rdah = rh;
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare(7'b1110000, "R1", 0);

        // R4 R5 tuned timing, reads and writes
        set_cfg(20'h40000, 20'hFFFFF, 1'b1, 1'b1, 5'd3, 1'b0, 1'b0);
        run(32'h4000_0010, 1'b0, 1'b0, "R4");
        run(32'h4000_0FFC, 1'b1, 1'b0, "R5");
        // R3 miss just outside the region
        run(32'h4000_1000, 1'b0, 1'b0, "R3");
        // R6 write hold, and no effect on reads
        set_cfg(20'h40000, 20'hFFFFF, 1'b1, 1'b0, 5'd0, 1'b1, 1'b0);
        run(32'h4000_0004, 1'b1, 1'b0, "R6");
        run(32'h4000_0004, 1'b0, 1'b0, "R6");
        // R7 read hold, and no effect on writes
        set_cfg(20'h40000, 20'hFFFFF, 1'b1, 1'b1, 5'd1, 1'b0, 1'b1);
        run(32'h4000_0008, 1'b0, 1'b0, "R7");
        run(32'h4000_0008, 1'b1, 1'b0, "R7");
        // R8 safe starting wait value with both holds
        set_cfg(20'h40000, 20'hFFFFF, 1'b1, 1'b1, 5'h1F, 1'b1, 1'b1);
        run(32'h4000_0100, 1'b1, 1'b0, "R8");
        // R2 partial mask: low tag bits not compared
        set_cfg(20'h40000, 20'hFFF00, 1'b1, 1'b0, 5'd2, 1'b0, 1'b0);
        run(32'h400A_B000, 1'b0, 1'b0, "R2");
        run(32'h4010_0000, 1'b0, 1'b0, "R2");
        // R10 disabled region misses at its own base
        set_cfg(20'h40000, 20'hFFFFF, 1'b0, 1'b0, 5'd2, 1'b0, 1'b0);
        run(32'h4000_0000, 1'b1, 1'b0, "R10");
        // R9 request held high through hit and miss cycles
        set_cfg(20'h40000, 20'hFFFFF, 1'b1, 1'b1, 5'd4, 1'b1, 1'b1);
        run(32'h4000_0020, 1'b0, 1'b1, "R9");
        run(32'h5000_0020, 1'b1, 1'b1, "R9");

        // random mix, checked against the R8 cycle formula
        for (int n = 0; n < 60; n++) begin
            logic [31:0] a;
            set_cfg(20'h40000 | 20'($urandom_range(0, 3)), 20'hFFFFC | 20'($urandom_range(0, 3)),
                    ($urandom_range(0, 7) != 0), 1'($urandom), 5'($urandom_range(0, 9)),
                    1'($urandom), 1'($urandom));
            a = {20'h40000 | 20'($urandom_range(0, 3)), 12'($urandom)};
            if ($urandom_range(0, 3) == 0) a[31:28] = 4'($urandom);
            run(a, 1'($urandom), 1'($urandom), "R8");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule